// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds a bank of interrupt sources and decides when each one is offered to a single downstream presenter. Every source carries an eight-bit priority, a level or message mode, a two-bit presented/queued state, a resend flag and a masked-pending flag. Trigger, end-of-interrupt and reject events arrive tagged with a source number. The block turns them into delivery requests that carry the source number and its priority. Requests go out one at a time over a valid/ready handshake, and the presenter answers each handshake with an accept bit.

Message sources coalesce their triggers. A second trigger that arrives while the source is still presented is only queued, and end-of-interrupt promotes the queued event. Level sources follow the line value that comes with each trigger. A refused delivery is not lost: the source keeps a resend flag, the bank raises a resend-needed indication, and a resend command retries the flagged sources in index order. A source whose priority is the masked value never reaches the presenter. It holds a masked-pending flag, and the held interrupt is delivered once software writes an unmasked priority.

Top module: `irq_src_bank`

## Requirements
- R1: After reset no request is valid, resend_needed is 0, every masked-pending bit is 0 and every source has the masked priority 8'hFF in message mode.
- R2: A message-mode trigger sets the state to {Q,P} = {old P, 1}, where bit 0 is P and bit 1 is Q. A delivery is requested only when P was 0 before the trigger, so the result is exactly P=1,Q=0.
- R3: End-of-interrupt on a message source shifts the state right by one, so Q moves into P and Q clears. If P is then 1, the source is delivered again.
- R4: In level mode (cfg_lsi=1) a trigger copies trig_lvl into P and requests delivery only when P rises. End-of-interrupt leaves the state unchanged and delivers again if P is still 1.
- R5: A source whose priority is 8'hFF when it is chosen for delivery produces no request and sets its mask_pend bit. This holds both for first deliveries and for resends.
- R6: A priority write that is not 8'hFF, made to a source whose mask_pend bit is set, clears that bit and delivers the held interrupt. A mask_pend bit clears only through such a write.
- R7: A handshake with rsp_accept=0 sets the resend flag of the refused source and sets resend_needed in the next cycle.
- R8: A rescan pulse clears resend_needed and every resend flag. It re-attempts delivery for exactly the flagged sources, lowest index first.
- R9: A reject event re-delivers its source whatever its presented/queued state and resend flag are.
- R10: At most one request is outstanding. While req_valid is high and req_ready is low, req_idx and req_prio hold.
- R11: Pending deliveries go out lowest index first. An event sampled at one clock edge can raise req_valid at the next edge at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write priority and mode of one source |
| cfg_idx | input | IDX_W | Source written |
| cfg_prio | input | 8 | New priority (8'hFF masks the source) |
| cfg_lsi | input | 1 | New mode: 1 level, 0 message |
| trig_valid | input | 1 | Trigger event |
| trig_idx | input | IDX_W | Source triggered |
| trig_lvl | input | 1 | Line value for level sources |
| eoi_valid | input | 1 | End-of-interrupt event |
| eoi_idx | input | IDX_W | Source ended |
| rej_valid | input | 1 | Presenter rejected a delivered interrupt |
| rej_idx | input | IDX_W | Source rejected |
| rescan | input | 1 | Resend command |
| req_ready | input | 1 | Presenter takes the request |
| rsp_accept | input | 1 | Presenter answer, valid with the handshake |
| req_valid | output | 1 | Delivery request |
| req_idx | output | IDX_W | Source number of the request |
| req_prio | output | 8 | Priority of the request |
| resend_needed | output | 1 | A refusal happened since the last rescan |
| mask_pend | output | NUM_SRC | Masked-pending bit of each source |

## Verification
On message sources the trigger patterns are a single trigger, a double trigger and end-of-interrupt with and without a queued event. These separate the coalescing rule from a plain edge detector. Level sources are driven with repeated high lines and a low line before end-of-interrupt, which shows whether redelivery follows P or the event count. Refusals are followed by a rescan, with a stalled presenter and several pending sources. This exposes the ordering, the handshake hold and the resend bookkeeping. A source is masked between its refusal and the rescan, and another is unmasked while holding an interrupt, so both paths of the masked-pending flag are covered.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

  typedef enum logic {
    DISP_IDLE,
    DISP_WAIT
  } disp_state_e;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_hit,
  input  logic              trig_lvl,
  input  logic              eoi_hit,
  input  logic              rej_hit,
  input  logic              cfg_hit,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_lsi,
  input  logic              take,
  input  logic              mask_hit,
  input  logic              fail,
  input  logic              rescan,
  output logic [PRIO_W-1:0] prio,
  output logic              want,
  output logic              resend,
  output logic              mpend
);
  // state bit 0 = presented, bit 1 = queued
  logic [PRIO_W-1:0] prio_q, prio_n;
  logic              lsi_q, lsi_n;
  logic [1:0]        pq_q, pq_n, pq_eoi;
  logic              want_q, want_n;
  logic              resend_q, resend_n;
  logic              mpend_q, mpend_n;
  logic              eoi_present, trig_present, cfg_unmask;

  always_comb begin
    pq_eoi = pq_q;
    if (eoi_hit && !lsi_q) pq_eoi = {1'b0, pq_q[1]};
    eoi_present = eoi_hit && pq_eoi[0];

    pq_n         = pq_eoi;
    trig_present = 1'b0;
    if (trig_hit) begin
      if (lsi_q) begin
        pq_n         = {pq_eoi[1], trig_lvl};
        trig_present = trig_lvl && !pq_eoi[0];
      end else begin
        pq_n         = {pq_eoi[0], 1'b1};
        trig_present = !pq_eoi[0];
      end
    end

    cfg_unmask = cfg_hit && mpend_q && (cfg_prio != PRIO_MASKED);

    want_n   = (want_q & ~take & ~mask_hit) | trig_present | eoi_present |
               rej_hit | cfg_unmask | (rescan & resend_q);
    resend_n = (resend_q & ~rescan) | fail;
    mpend_n  = (mpend_q & ~cfg_unmask) | mask_hit;
    prio_n   = cfg_prio;
    lsi_n    = cfg_lsi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q   <= PRIO_MASKED;
      lsi_q    <= 1'b0;
      pq_q     <= 2'b00;
      want_q   <= 1'b0;
      resend_q <= 1'b0;
      mpend_q  <= 1'b0;
    end else begin
      if (cfg_hit) begin
        prio_q <= prio_n;
        lsi_q  <= lsi_n;
      end
      pq_q     <= pq_n;
      want_q   <= want_n;
      resend_q <= resend_n;
      mpend_q  <= mpend_n;
    end
  end

  assign prio   = prio_q;
  assign want   = want_q;
  assign resend = resend_q;
  assign mpend  = mpend_q;
endmodule

// File: rtl/irq_src_dispatch.sv
module irq_src_dispatch
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         want,
  input  logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
  input  logic                       req_ready,
  input  logic                       rsp_accept,
  input  logic                       rescan,
  output logic [NUM_SRC-1:0]         take,
  output logic [NUM_SRC-1:0]         mask_hit,
  output logic [NUM_SRC-1:0]         fail,
  output logic                       req_valid,
  output logic [IDX_W-1:0]           req_idx,
  output logic [PRIO_W-1:0]          req_prio,
  output logic                       resend_needed
);
  disp_state_e       state_q, state_n;
  logic [IDX_W-1:0]  idx_q, idx_n, pick_idx;
  logic [PRIO_W-1:0] prio_q, prio_n, pick_prio;
  logic              rn_q, rn_n, any_want, hs;

  // lowest index wins
  always_comb begin
    any_want = |want;
    pick_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (want[i]) pick_idx = IDX_W'(i);
    end
    pick_prio = prio_flat[pick_idx*PRIO_W +: PRIO_W];
  end

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    prio_n   = prio_q;
    take     = '0;
    mask_hit = '0;
    fail     = '0;
    hs       = (state_q == DISP_WAIT) && req_ready;
    case (state_q)
      DISP_IDLE: begin
        if (any_want) begin
          if (pick_prio == PRIO_MASKED) begin
            mask_hit[pick_idx] = 1'b1;
          end else begin
            take[pick_idx] = 1'b1;
            state_n        = DISP_WAIT;
            idx_n          = pick_idx;
            prio_n         = pick_prio;
          end
        end
      end
      DISP_WAIT: begin
        if (hs) begin
          state_n = DISP_IDLE;
          if (!rsp_accept) fail[idx_q] = 1'b1;
        end
      end
      default: state_n = DISP_IDLE;
    endcase
    rn_n = (rn_q & ~rescan) | (|fail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DISP_IDLE;
      idx_q   <= '0;
      prio_q  <= PRIO_MASKED;
      rn_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      if (state_q == DISP_IDLE) begin
        idx_q  <= idx_n;
        prio_q <= prio_n;
      end
      rn_q <= rn_n;
    end
  end

  assign req_valid     = (state_q == DISP_WAIT);
  assign req_idx       = idx_q;
  assign req_prio      = prio_q;
  assign resend_needed = rn_q;
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [7:0]         cfg_prio,
  input  logic               cfg_lsi,
  input  logic               trig_valid,
  input  logic [IDX_W-1:0]   trig_idx,
  input  logic               trig_lvl,
  input  logic               eoi_valid,
  input  logic [IDX_W-1:0]   eoi_idx,
  input  logic               rej_valid,
  input  logic [IDX_W-1:0]   rej_idx,
  input  logic               rescan,
  input  logic               req_ready,
  input  logic               rsp_accept,
  output logic               req_valid,
  output logic [IDX_W-1:0]   req_idx,
  output logic [7:0]         req_prio,
  output logic               resend_needed,
  output logic [NUM_SRC-1:0] mask_pend
);
  logic [NUM_SRC-1:0]        want, resend_vec, take, mask_hit, fail;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [IDX_W-1:0] SLOT_ID = IDX_W'(g);
    irq_src_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_hit (trig_valid && (trig_idx == SLOT_ID)),
      .trig_lvl (trig_lvl),
      .eoi_hit  (eoi_valid && (eoi_idx == SLOT_ID)),
      .rej_hit  (rej_valid && (rej_idx == SLOT_ID)),
      .cfg_hit  (cfg_we && (cfg_idx == SLOT_ID)),
      .cfg_prio (cfg_prio),
      .cfg_lsi  (cfg_lsi),
      .take     (take[g]),
      .mask_hit (mask_hit[g]),
      .fail     (fail[g]),
      .rescan   (rescan),
      .prio     (prio_flat[g*PRIO_W +: PRIO_W]),
      .want     (want[g]),
      .resend   (resend_vec[g]),
      .mpend    (mask_pend[g])
    );
  end

  irq_src_dispatch #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_disp (
    .clk           (clk),
    .rst_n         (rst_n),
    .want          (want),
    .prio_flat     (prio_flat),
    .req_ready     (req_ready),
    .rsp_accept    (rsp_accept),
    .rescan        (rescan),
    .take          (take),
    .mask_hit      (mask_hit),
    .fail          (fail),
    .req_valid     (req_valid),
    .req_idx       (req_idx),
    .req_prio      (req_prio),
    .resend_needed (resend_needed)
  );

  // resend flags are state observed only through redelivery
  logic unused_resend;
  assign unused_resend = ^resend_vec;
endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk #(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               rescan,
  input logic               req_ready,
  input logic               rsp_accept,
  input logic               req_valid,
  input logic [IDX_W-1:0]   req_idx,
  input logic [7:0]         req_prio,
  input logic               resend_needed,
  input logic [NUM_SRC-1:0] mask_pend
);
  assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_idx) && $stable(req_prio));

  assert_no_masked_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_prio != 8'hFF);

  assert_refusal_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !rsp_accept |=> resend_needed);

  assert_rescan_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rescan && !(req_valid && req_ready && !rsp_accept) |=> !resend_needed);

  assert_mpend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (($past(mask_pend) & ~mask_pend) == '0));
endmodule

bind irq_src_bank irq_src_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .rescan        (rescan),
  .req_ready     (req_ready),
  .rsp_accept    (rsp_accept),
  .req_valid     (req_valid),
  .req_idx       (req_idx),
  .req_prio      (req_prio),
  .resend_needed (resend_needed),
  .mask_pend     (mask_pend)
);

// File: tb/irq_src_bank_tb.sv
module irq_src_bank_tb;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk, rst_n;
  logic cfg_we, cfg_lsi, trig_valid, trig_lvl, eoi_valid, rej_valid, rescan;
  logic req_ready, rsp_accept;
  logic [IW-1:0] cfg_idx, trig_idx, eoi_idx, rej_idx;
  logic [7:0] cfg_prio;
  logic req_valid, resend_needed;
  logic [IW-1:0] req_idx;
  logic [7:0] req_prio;
  logic [N-1:0] mask_pend;

  int total = 0, bad = 0, cycles = 0;
  string phase = "R1";

  irq_src_bank #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
    .cfg_lsi(cfg_lsi), .trig_valid(trig_valid), .trig_idx(trig_idx), .trig_lvl(trig_lvl),
    .eoi_valid(eoi_valid), .eoi_idx(eoi_idx), .rej_valid(rej_valid), .rej_idx(rej_idx),
    .rescan(rescan), .req_ready(req_ready), .rsp_accept(rsp_accept), .req_valid(req_valid),
    .req_idx(req_idx), .req_prio(req_prio), .resend_needed(resend_needed), .mask_pend(mask_pend)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_prio[N];
  bit m_lsi[N], m_p[N], m_q[N];
  bit [N-1:0] m_want, m_res, m_mp;
  bit m_busy, m_rn;
  int m_idx, m_pr;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_prio[i] = 255; m_lsi[i] = 0; m_p[i] = 0; m_q[i] = 0;
    end
    m_want = '0; m_res = '0; m_mp = '0; m_busy = 0; m_rn = 0; m_idx = 0; m_pr = 255;
  endtask

  task automatic model_step();
    bit hs, fl;
    int pick, tk, mk, e, t, c;
    bit [N-1:0] res0, mp0;
    res0 = m_res; mp0 = m_mp;
    hs = m_busy && req_ready;
    fl = hs && !rsp_accept;
    pick = -1; tk = -1; mk = -1;
    if (!m_busy)
      for (int i = 0; i < N; i++) if (m_want[i] && pick < 0) pick = i;
    if (pick >= 0) begin
      if (m_prio[pick] == 255) mk = pick; else tk = pick;
    end
    if (tk >= 0) m_want[tk] = 0;
    if (mk >= 0) begin m_want[mk] = 0; m_mp[mk] = 1; end
    if (rescan)
      for (int i = 0; i < N; i++) if (res0[i]) begin m_want[i] = 1; m_res[i] = 0; end
    if (fl) m_res[m_idx] = 1;
    m_rn = (m_rn && !rescan) || fl;
    if (m_busy) begin
      if (hs) m_busy = 0;
    end else if (tk >= 0) begin
      m_busy = 1; m_idx = tk; m_pr = m_prio[tk];
    end
    if (eoi_valid) begin
      e = int'(eoi_idx);
      if (!m_lsi[e]) begin m_p[e] = m_q[e]; m_q[e] = 0; end
      if (m_p[e]) m_want[e] = 1;
    end
    if (trig_valid) begin
      t = int'(trig_idx);
      if (m_lsi[t]) begin
        if (trig_lvl && !m_p[t]) m_want[t] = 1;
        m_p[t] = trig_lvl;
      end else begin
        if (!m_p[t]) m_want[t] = 1;
        m_q[t] = m_p[t]; m_p[t] = 1;
      end
    end
    if (rej_valid) m_want[int'(rej_idx)] = 1;
    if (cfg_we) begin
      c = int'(cfg_idx);
      if (mp0[c] && cfg_prio != 8'hFF) begin m_want[c] = 1; m_mp[c] = 0; end
      m_prio[c] = int'(cfg_prio); m_lsi[c] = cfg_lsi;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ok;
      ok = (req_valid == m_busy) && (resend_needed == m_rn) && (mask_pend == m_mp);
      if (m_busy) ok = ok && (int'(req_idx) == m_idx) && (int'(req_prio) == m_pr);
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL %s cycle: act v=%0b i=%0d p=%0d rn=%0b mp=%h exp v=%0b i=%0d p=%0d rn=%0b mp=%h",
                 phase, req_valid, req_idx, req_prio, resend_needed, mask_pend,
                 m_busy, m_idx, m_pr, m_rn, m_mp);
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic int pr(int i);
    return i * 4 + 1;
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_cfg(int i, int p, bit lsi);
    cfg_we = 1; cfg_idx = IW'(i); cfg_prio = 8'(p); cfg_lsi = lsi;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_trig(int i, bit lvl);
    trig_valid = 1; trig_idx = IW'(i); trig_lvl = lvl;
    @(negedge clk); trig_valid = 0;
  endtask

  task automatic do_eoi(int i);
    eoi_valid = 1; eoi_idx = IW'(i);
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic do_rej(int i);
    rej_valid = 1; rej_idx = IW'(i);
    @(negedge clk); rej_valid = 0;
  endtask

  task automatic do_rescan();
    rescan = 1;
    @(negedge clk); rescan = 0;
  endtask

  task automatic await_req(int idx, int p, string tag);
    for (int k = 0; k < 8 && !req_valid; k++) @(negedge clk);
    check(req_valid && int'(req_idx) == idx && int'(req_prio) == p, tag,
          req_valid ? int'(req_idx) : -1, idx);
    @(negedge clk);
  endtask

  task automatic expect_quiet(int n, string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      if (req_valid) seen = 1;
      @(negedge clk);
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idx = '0; cfg_prio = '0; cfg_lsi = 0;
    trig_valid = 0; trig_idx = '0; trig_lvl = 0; eoi_valid = 0; eoi_idx = '0;
    rej_valid = 0; rej_idx = '0; rescan = 0; req_ready = 1; rsp_accept = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    phase = "R1";
    check(!req_valid && !resend_needed && mask_pend == '0, "R1 reset outputs",
          int'(req_valid) + int'(resend_needed) + int'(|mask_pend), 0);

    // R5: default priority is masked, trigger is held
    phase = "R5";
    do_trig(3, 0);
    expect_quiet(3, "R5 masked source silent");
    check(mask_pend[3] == 1'b1, "R5 mask_pend set", int'(mask_pend[3]), 1);

    // R6: unmask delivers the held interrupt
    phase = "R6";
    do_cfg(3, pr(3), 0);
    await_req(3, pr(3), "R6 unmask delivers");
    check(mask_pend[3] == 1'b0, "R6 mask_pend cleared", int'(mask_pend[3]), 0);
    for (int i = 0; i < N; i++) if (i != 3) do_cfg(i, pr(i), 0);
    repeat (2) @(negedge clk);

    // R2 / R3: message coalescing
    phase = "R2";
    do_trig(5, 0);
    await_req(5, pr(5), "R2 first trigger presents");
    do_trig(5, 0);
    expect_quiet(3, "R2 second trigger only queues");
    phase = "R3";
    do_eoi(5);
    await_req(5, pr(5), "R3 eoi promotes queued");
    do_eoi(5);
    expect_quiet(3, "R3 eoi with nothing queued");

    // R4: level mode
    phase = "R4";
    do_cfg(7, pr(7), 1);
    do_trig(7, 1);
    await_req(7, pr(7), "R4 rising level delivers");
    do_trig(7, 1);
    expect_quiet(3, "R4 level still high no new request");
    do_eoi(7);
    await_req(7, pr(7), "R4 eoi with level high redelivers");
    do_trig(7, 0);
    do_eoi(7);
    expect_quiet(3, "R4 eoi with level low silent");

    // R7 / R8: refusal and rescan order
    phase = "R7";
    rsp_accept = 0;
    do_trig(9, 0);
    await_req(9, pr(9), "R7 first attempt src9");
    do_trig(2, 0);
    await_req(2, pr(2), "R7 first attempt src2");
    @(negedge clk);
    check(resend_needed == 1'b1, "R7 resend_needed raised", int'(resend_needed), 1);
    rsp_accept = 1;
    phase = "R8";
    do_rescan();
    check(resend_needed == 1'b0, "R8 rescan clears indication", int'(resend_needed), 0);
    await_req(2, pr(2), "R8 rescan lower index first");
    await_req(9, pr(9), "R8 rescan then src9");
    do_rescan();
    expect_quiet(3, "R8 second rescan has no flagged source");

    // R5 on resend path, then R6 again
    phase = "R5";
    rsp_accept = 0;
    do_trig(6, 0);
    await_req(6, pr(6), "R5 attempt before masking");
    rsp_accept = 1;
    do_cfg(6, 255, 0);
    do_rescan();
    expect_quiet(3, "R5 masked resend silent");
    check(mask_pend[6] == 1'b1, "R5 masked resend held", int'(mask_pend[6]), 1);
    phase = "R6";
    do_cfg(6, pr(6), 0);
    await_req(6, pr(6), "R6 unmask after masked resend");

    // R9: reject redelivers regardless of state
    phase = "R9";
    do_rej(11);
    await_req(11, pr(11), "R9 reject redelivers");

    // R10 / R11: stall and ordering
    phase = "R10";
    req_ready = 0;
    do_trig(12, 0);
    do_trig(4, 0);
    do_trig(1, 0);
    begin
      bit held = 1;
      for (int k = 0; k < 5; k++) begin
        if (!(req_valid && req_idx == 4'd12 && req_prio == 8'(pr(12)))) held = 0;
        @(negedge clk);
      end
      check(held, "R10 request held under stall", int'(req_idx), 12);
    end
    req_ready = 1;
    @(negedge clk);
    phase = "R11";
    await_req(1, pr(1), "R11 lowest pending first");
    await_req(4, pr(4), "R11 next pending");
    expect_quiet(3, "R11 queue drained");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule